// File: doc/BRIEF.md
# Lead-Lag Switching Frequency Stepper

This block picks the switching clock of a switched-capacitor step-down converter from four binary-related rates. All four are divided from one fast sampling clock, each with a 50% duty cycle. The slowest of them also serves as a fixed reference. An analog stage outside the block supplies a pseudo-clock. It rises with the reference, and its high time stretches when load current grows and shrinks when load current falls. Once per reference period the block counts how many sampling cycles the pseudo-clock was high and compares that count with the reference high time. A lag (longer high time) or a lead (shorter high time) larger than a programmable dead band moves a saturating frequency index one step up or down.

Two calibration inputs can force a step either way, and they take precedence over the lead/lag result. A soft-start inhibit blocks every increase. In the ultra-light-load idle mode the switching clock output is held low, except while a ripple comparator asks for pulses. The index changes only at a reference period boundary, and the gate changes only while the selected clock is low. The output therefore carries whole pulses only.

Top module: `lagstep_clk_sel`

## Requirements
- R1: With the default parameters, `sysClk_o` is the rate picked by `freqIdx_o`: index 0 gives a 32-cycle period, 1 gives 16, 2 gives 8 and 3 gives 4. Each rate is high for the first half of its period, and every rate starts high on the first cycle of each reference period.
- R2: `refClk_o` has a 32-cycle period. It is high for cycles 0 to 15 of each reference period and low for cycles 16 to 31.
- R3: Let H be the number of sampling cycles in one reference period during which the pseudo-clock was high. If H minus 16 is greater than `thresh_i`, the index goes up by one at the next reference period boundary.
- R4: If 16 minus H is greater than `thresh_i`, the index goes down by one at the next boundary.
- R5: If the absolute value of H minus 16 is at most `thresh_i`, the index keeps its value.
- R6: The index saturates. It stays at 3 when an increase is requested and at 0 when a decrease is requested.
- R7: The calibration inputs are sampled in the last cycle of the period. `calUp_i` alone forces an increase and `calDn_i` alone forces a decrease, whatever the lead/lag result. When both are high the index holds.
- R8: While `softInhibit_i` is high in the last cycle of a period, the index does not go up from either source. Decreases still take effect.
- R9: `freqIdx_o` changes only in the cycle where `refClk_o` rises, and by exactly one step.
- R10: The output gate takes the value (not `deepGreen_i`) or `rippleReq_i` at each edge that enters a low phase of the selected rate. While the gate is closed `sysClk_o` stays low. A pulse that has started always runs to its full width.
- R11: During reset the index is 0, `sysClk_o` is low, `refClk_o` is high and the gate is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock that all rates are divided from |
| rst_n | input | 1 | Asynchronous active-low reset |
| pseudoClk_i | input | 1 | Duty-modulated pseudo-clock, asynchronous |
| thresh_i | input | 5 | Dead-band threshold in sampling cycles |
| calUp_i | input | 1 | Calibration request to raise the frequency |
| calDn_i | input | 1 | Calibration request to lower the frequency |
| softInhibit_i | input | 1 | Blocks all frequency increases |
| deepGreen_i | input | 1 | Ultra-light-load idle, masks the switching clock |
| rippleReq_i | input | 1 | Ripple comparator request that lets pulses through in idle |
| sysClk_o | output | 1 | Selected, gated switching clock |
| refClk_o | output | 1 | Reference clock (slowest rate) |
| freqIdx_o | output | 2 | Current frequency index, 0 = slowest |

## Verification
A wrong index shows up within one reference period: the next reference period starts with a `sysClk_o` period that differs from the expected rate, and `freqIdx_o` itself differs. A miscount in the high-time accumulator or in the dead-band comparison is harder to see. It leaves the clocks intact and appears only as a wrong step, or a missing one, at the following boundary, so the bench sweeps every high time from 0 to 30 against several thresholds. A gate held in the wrong state shows as missing or extra pulses from the next low phase onward.

// File: rtl/lagstep_pkg.sv
package lagstep_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic stepUp;   // advance the index at this period boundary
    logic stepDn;   // retreat the index at this period boundary
    logic gateReq;  // requested gate level, taken in a low phase
  } freqStrobe_t;

  // Outcome of one period's evaluation.
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DN   = 2'd2
  } stepDec_e;

endpackage

// File: rtl/lagstep_datapath.sv
module lagstep_datapath
  import lagstep_pkg::*;
#(
  parameter int HALF_LOG    = 1,
  parameter int NUM_RATES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW    = HALF_LOG + NUM_RATES,
  localparam int IDX_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pseudoClk,
  input  freqStrobe_t      strobe,
  output logic             periodEnd,
  output logic [CW:0]      measHigh,
  output logic [IDX_W-1:0] idxQ,
  output logic             sysClk,
  output logic             refClk
);

  logic [CW-1:0]          phaseCnt;
  logic [CW-1:0]          phaseNext;
  logic [CW:0]            hiCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   psSync;
  logic [IDX_W-1:0]       idxNext;
  logic [NUM_RATES-1:0]   rateNext;
  logic                   selNext;
  logic                   gateQ;
  logic                   gateNew;
  logic                   sysClkQ;
  logic                   refQ;

  // Phase counter: one full wrap equals one reference period.
  assign phaseNext = phaseCnt + CW'(1);
  assign periodEnd = &phaseCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseCnt <= '0;
    else        phaseCnt <= phaseNext;
  end

  // Synchronizer for the asynchronous pseudo-clock.
  generate
    if (SYNC_STAGES > 1) begin : g_syncChain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], pseudoClk};
      end
    end else begin : g_syncSingle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= pseudoClk;
      end
    end
  endgenerate
  assign psSync = syncQ[SYNC_STAGES-1];

  // High-time accumulator, restarted at each period boundary.
  assign measHigh = hiCnt + {{CW{1'b0}}, psSync};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hiCnt <= '0;
    else if (periodEnd) hiCnt <= '0;
    else                hiCnt <= measHigh;
  end

  // Frequency index.
  always_comb begin
    idxNext = idxQ;
    if (strobe.stepUp)      idxNext = idxQ + IDX_W'(1);
    else if (strobe.stepDn) idxNext = idxQ - IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idxQ <= '0;
    else        idxQ <= idxNext;
  end

  // Divided rates for the next cycle; rate 0 is the slowest.
  generate
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
      assign rateNext[r] = ~phaseNext[CW-1-r];
    end
  endgenerate

  assign selNext = rateNext[idxNext];
  // The gate may move only on an edge that enters a low phase.
  assign gateNew = selNext ? gateQ : strobe.gateReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateQ   <= 1'b0;
      sysClkQ <= 1'b0;
      refQ    <= 1'b1;
    end else begin
      gateQ   <= gateNew;
      sysClkQ <= selNext & gateNew;
      refQ    <= rateNext[0];
    end
  end

  assign sysClk = sysClkQ;
  assign refClk = refQ;

endmodule

// File: rtl/lagstep_control.sv
module lagstep_control
  import lagstep_pkg::*;
#(
  parameter int HALF_LOG  = 1,
  parameter int NUM_RATES = 4,
  localparam int CW    = HALF_LOG + NUM_RATES,
  localparam int IDX_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic             periodEnd,
  input  logic [CW:0]      measHigh,
  input  logic [IDX_W-1:0] idx,
  input  logic [CW-1:0]    thresh,
  input  logic             calUp,
  input  logic             calDn,
  input  logic             softInhibit,
  input  logic             deepGreen,
  input  logic             rippleReq,
  output freqStrobe_t      strobe
);

  localparam logic [CW+1:0]    REF_HIGH = (CW+2)'(1) << (CW-1);
  localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(NUM_RATES - 1);

  logic signed [CW+1:0] diffS;
  logic signed [CW+1:0] thrS;
  logic                 lagOver;
  logic                 leadOver;
  stepDec_e             dec;

  // Signed excess of measured high time over the reference high time.
  assign diffS    = $signed({1'b0, measHigh}) - $signed(REF_HIGH);
  assign thrS     = $signed({2'b00, thresh});
  assign lagOver  = diffS > thrS;
  assign leadOver = (-diffS) > thrS;

  // Calibration overrides lead/lag; a conflicting pair holds.
  always_comb begin
    dec = DEC_HOLD;
    if (calUp && calDn)  dec = DEC_HOLD;
    else if (calUp)      dec = DEC_UP;
    else if (calDn)      dec = DEC_DN;
    else if (lagOver)    dec = DEC_UP;
    else if (leadOver)   dec = DEC_DN;
  end

  always_comb begin
    strobe.stepUp  = periodEnd && (dec == DEC_UP) && !softInhibit && (idx != IDX_MAX);
    strobe.stepDn  = periodEnd && (dec == DEC_DN) && (idx != '0);
    strobe.gateReq = !deepGreen || rippleReq;
  end

endmodule

// File: rtl/lagstep_clk_sel.sv
module lagstep_clk_sel
  import lagstep_pkg::*;
#(
  parameter int HALF_LOG    = 1,
  parameter int NUM_RATES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW    = HALF_LOG + NUM_RATES,
  localparam int IDX_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pseudoClk_i,
  input  logic [CW-1:0]    thresh_i,
  input  logic             calUp_i,
  input  logic             calDn_i,
  input  logic             softInhibit_i,
  input  logic             deepGreen_i,
  input  logic             rippleReq_i,
  output logic             sysClk_o,
  output logic             refClk_o,
  output logic [IDX_W-1:0] freqIdx_o
);

  freqStrobe_t      strobe;
  logic             periodEnd;
  logic [CW:0]      measHigh;
  logic [IDX_W-1:0] idxQ;

  lagstep_datapath #(
    .HALF_LOG   (HALF_LOG),
    .NUM_RATES  (NUM_RATES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pseudoClk(pseudoClk_i),
    .strobe   (strobe),
    .periodEnd(periodEnd),
    .measHigh (measHigh),
    .idxQ     (idxQ),
    .sysClk   (sysClk_o),
    .refClk   (refClk_o)
  );

  lagstep_control #(
    .HALF_LOG (HALF_LOG),
    .NUM_RATES(NUM_RATES)
  ) u_ctl (
    .periodEnd  (periodEnd),
    .measHigh   (measHigh),
    .idx        (idxQ),
    .thresh     (thresh_i),
    .calUp      (calUp_i),
    .calDn      (calDn_i),
    .softInhibit(softInhibit_i),
    .deepGreen  (deepGreen_i),
    .rippleReq  (rippleReq_i),
    .strobe     (strobe)
  );

  assign freqIdx_o = idxQ;

endmodule

// File: rtl/lagstep_chk.sv
module lagstep_chk #(
  parameter int HALF_LOG  = 1,
  parameter int NUM_RATES = 4,
  localparam int CW    = HALF_LOG + NUM_RATES,
  localparam int IDX_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             calUp_i,
  input logic             calDn_i,
  input logic             softInhibit_i,
  input logic             sysClk_o,
  input logic             refClk_o,
  input logic [IDX_W-1:0] freqIdx_o
);

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_RATES - 1);

  logic [CW:0] hiRun;
  logic [CW:0] expHalf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hiRun <= '0;
    else if (sysClk_o) hiRun <= hiRun + (CW+1)'(1);
    else               hiRun <= '0;
  end

  assign expHalf = (CW+1)'(1) << (HALF_LOG + NUM_RATES - 1 - int'(freqIdx_o));

  // R9
  idx_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freqIdx_o) |-> $rose(refClk_o));

  // R9 R6
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freqIdx_o) |->
      (({1'b0, freqIdx_o}) == ({1'b0, $past(freqIdx_o)} + (IDX_W+1)'(1))) ||
      (({1'b0, freqIdx_o}) + (IDX_W+1)'(1) == ({1'b0, $past(freqIdx_o)})));

  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refClk_o) && $past(softInhibit_i)) |-> (freqIdx_o <= $past(freqIdx_o)));

  // R7
  cal_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refClk_o) && $past(calUp_i && !calDn_i && !softInhibit_i && (freqIdx_o != IDX_MAX)))
      |-> (freqIdx_o == $past(freqIdx_o) + IDX_W'(1)));

  // R7
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refClk_o) && $past(calUp_i && calDn_i)) |-> (freqIdx_o == $past(freqIdx_o)));

  // R1 R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysClk_o) |-> (hiRun == expHalf));

endmodule

bind lagstep_clk_sel lagstep_chk #(
  .HALF_LOG (HALF_LOG),
  .NUM_RATES(NUM_RATES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .calUp_i      (calUp_i),
  .calDn_i      (calDn_i),
  .softInhibit_i(softInhibit_i),
  .sysClk_o     (sysClk_o),
  .refClk_o     (refClk_o),
  .freqIdx_o    (freqIdx_o)
);

// File: tb/sim_lagstep_clk_sel.sv
`timescale 1ns/1ps
module sim_lagstep_clk_sel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pseudoClk_i = 1'b0;
  logic [4:0] thresh_i = 5'd0;
  logic       calUp_i = 1'b0;
  logic       calDn_i = 1'b0;
  logic       softInhibit_i = 1'b0;
  logic       deepGreen_i = 1'b0;
  logic       rippleReq_i = 1'b0;
  logic       sysClk_o;
  logic       refClk_o;
  logic [1:0] freqIdx_o;

  int checks = 0;
  int failures = 0;
  int expIdx = 0;
  bit benchGate = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lagstep_clk_sel u0 (
    .clk(clk), .rst_n(rst_n), .pseudoClk_i(pseudoClk_i), .thresh_i(thresh_i),
    .calUp_i(calUp_i), .calDn_i(calDn_i), .softInhibit_i(softInhibit_i),
    .deepGreen_i(deepGreen_i), .rippleReq_i(rippleReq_i),
    .sysClk_o(sysClk_o), .refClk_o(refClk_o), .freqIdx_o(freqIdx_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Rate idx at period cycle c: high in the first half of its period.
  function automatic bit rateVal(input int c, input int idx);
    return ((c >> (4 - idx)) & 1) == 0;
  endfunction

  function automatic int modelNext(input int idx, input int h);
    int d = h - 16;
    int thr = int'(thresh_i);
    bit up = 0;
    bit dn = 0;
    if (calUp_i && calDn_i) begin up = 0; dn = 0; end
    else if (calUp_i) up = 1;
    else if (calDn_i) dn = 1;
    else if (d > thr) up = 1;
    else if (-d > thr) dn = 1;
    if (softInhibit_i) up = 0;
    if (up && idx < 3) return idx + 1;
    if (dn && idx > 0) return idx - 1;
    return idx;
  endfunction

  // One reference period, starting at the negedge where the phase is 0.
  task automatic doPeriod(input int h, input string waveTag, input int dgAt, input bit dgVal);
    int sysErr = 0;
    int refErr = 0;
    int idxErr = 0;
    int nextI;
    for (int c = 0; c < 32; c++) begin
      pseudoClk_i = (c < h);
      if (c == dgAt) deepGreen_i = dgVal;
      if (sysClk_o !== (rateVal(c, expIdx) && benchGate)) sysErr++;
      if (refClk_o !== (c < 16)) refErr++;
      if (int'(freqIdx_o) != expIdx) idxErr++;
      nextI = (c == 31) ? modelNext(expIdx, h) : expIdx;
      if (!rateVal((c + 1) % 32, nextI)) benchGate = !deepGreen_i || rippleReq_i;
      expIdx = nextI;
      @(negedge clk);
    end
    check(sysErr == 0, {waveTag, " switching clock shape"}, sysErr, 0);
    check(refErr == 0, "R2 reference clock shape", refErr, 0);
    check(idxErr == 0, "R9 index stable inside period", idxErr, 0);
  endtask

  task automatic stepCheck(input int h, input string tag);
    doPeriod(h, "R1", -1, 1'b0);
    check(int'(freqIdx_o) == expIdx, tag, int'(freqIdx_o), expIdx);
  endtask

  function automatic string sweepTag(input int h, input int thr);
    if (h - 16 > thr) return "R3 lag step up";
    if (16 - h > thr) return "R4 lead step down";
    return "R5 dead band hold";
  endfunction

  initial begin
    int thrList[4] = '{0, 3, 7, 15};
    repeat (3) @(negedge clk);
    // R11 reset state
    check(freqIdx_o == 2'd0, "R11 reset index", int'(freqIdx_o), 0);
    check(sysClk_o == 1'b0, "R11 reset sysClk", int'(sysClk_o), 0);
    check(refClk_o == 1'b1, "R11 reset refClk", int'(refClk_o), 1);
    rst_n = 1'b1;

    // Dead-band sweep from index 1 over every high time.
    foreach (thrList[t]) begin
      thresh_i = 5'(thrList[t]);
      for (int h = 0; h <= 30; h++) begin
        calDn_i = 1'b1;
        repeat (3) stepCheck(16, "R7 calibration down");
        calDn_i = 1'b0; calUp_i = 1'b1;
        stepCheck(16, "R7 calibration up");
        calUp_i = 1'b0;
        stepCheck(h, sweepTag(h, thrList[t]));
      end
    end

    // R6 saturation at both ends.
    thresh_i = 5'd2;
    repeat (4) stepCheck(30, "R3 lag step up");
    repeat (2) stepCheck(30, "R6 saturate at top");
    repeat (4) stepCheck(0, "R4 lead step down");
    repeat (2) stepCheck(0, "R6 saturate at bottom");

    // R7 calibration overrides lead/lag.
    calUp_i = 1'b1; stepCheck(0, "R7 cal up over lead");
    calUp_i = 1'b0; calDn_i = 1'b1; stepCheck(30, "R7 cal down over lag");
    calUp_i = 1'b1; stepCheck(30, "R7 both cal hold");
    calUp_i = 1'b1; stepCheck(0, "R7 both cal hold");
    calUp_i = 1'b0; calDn_i = 1'b0;

    // R8 soft-start inhibit.
    softInhibit_i = 1'b1;
    stepCheck(30, "R8 inhibit blocks lag up");
    calUp_i = 1'b1; stepCheck(16, "R8 inhibit blocks cal up");
    calUp_i = 1'b0; calDn_i = 1'b1; stepCheck(16, "R8 decrease still allowed");
    calDn_i = 1'b0; stepCheck(0, "R8 lead decrease allowed");
    softInhibit_i = 1'b0;

    // R10 idle mask: enter mid-pulse at the slowest rate, then release.
    calDn_i = 1'b1; repeat (3) stepCheck(16, "R7 calibration down"); calDn_i = 1'b0;
    doPeriod(16, "R10 gate closes after whole pulse", 4, 1'b1);
    doPeriod(16, "R10 masked period", -1, 1'b0);
    deepGreen_i = 1'b1;
    doPeriod(16, "R10 masked period", -1, 1'b1);
    rippleReq_i = 1'b1;
    doPeriod(16, "R10 ripple request opens gate", -1, 1'b1);
    doPeriod(16, "R10 ripple pulses", -1, 1'b1);
    rippleReq_i = 1'b0; deepGreen_i = 1'b0;
    calUp_i = 1'b1; stepCheck(16, "R7 calibration up"); stepCheck(16, "R7 calibration up");
    calUp_i = 1'b0;
    doPeriod(16, "R10 mask at fast rate", 3, 1'b1);
    doPeriod(16, "R10 masked fast period", -1, 1'b1);
    deepGreen_i = 1'b0;
    doPeriod(16, "R10 gate reopens", -1, 1'b0);
    doPeriod(16, "R1", -1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule